// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block turns an asynchronous serial line into bytes. Each frame has one low start bit, then the data bits with the least significant bit first, then one or more high stop bits. Every bit lasts `OVERSAMPLE` pulses of a clock-enable input, `sample_en`. The line first passes through a two-flop synchroniser. A falling line starts a candidate frame, and the receiver checks that candidate again at the middle of the start bit. It then samples each later bit at its centre.

A finished byte goes into a holding register and appears on a valid/ready output. The byte stays on `rx_data` while the next frame is being shifted in. Back-pressure rules: `rx_valid` stays high and `rx_data` does not change until a cycle with `rx_ready` high. That cycle consumes the byte. A new frame that completes while the previous byte is still unconsumed is dropped, and the overrun flag is raised.

The block raises three sticky error flags. Overrun means a byte was lost because the previous one had not been read. Underrun means a read was attempted with nothing held. Break means a frame arrived with all data bits zero and a low stop bit. A frame whose stop bit is low is never delivered. After such a frame, the receiver waits for the line to go high again before it looks for another start.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_valid`, `rx_data` and all three error flags are 0.
- R2: A frame is a low start bit, `DATA_BITS` data bits sent least significant bit first, and `STOP_BITS` high stop bits, each lasting `OVERSAMPLE` enables. A well-formed frame puts its byte on `rx_data` with `rx_valid` high.
- R3: A low line is taken as a start bit only if it is still low `OVERSAMPLE/2` enables after the first low sample. A shorter low pulse produces no byte.
- R4: Once `rx_valid` is high, it and `rx_data` hold until a cycle with `rx_ready` high. That cycle clears `rx_valid`, and `rx_data` keeps its value afterwards.
- R5: While a byte is held and the next frame is being received, `rx_data` does not change.
- R6: If a well-formed frame completes while `rx_valid` is high and `rx_ready` is low, `err_overrun` is set. The new byte is discarded and the held byte is kept.
- R7: If a frame completes in the same cycle that `rx_ready` consumes the held byte, the new byte is loaded, `rx_valid` stays high, and no overrun is flagged.
- R8: `rx_ready` high while `rx_valid` is low sets `err_underrun`.
- R9: A frame with any low stop-bit sample is not delivered. If all of its data bits are also 0, `err_break` is set; otherwise no flag changes.
- R10: After a frame with a low stop bit, no new frame starts until the line has been seen high. A line held low produces no bytes.
- R11: Each error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Oversampling clock-enable, `OVERSAMPLE` pulses per bit |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_ready | input | 1 | Consumer ready; consumes the held byte when `rx_valid` is high |
| rx_data | output | DATA_BITS | Held received byte |
| rx_valid | output | 1 | Held byte not yet consumed |
| err_overrun | output | 1 | Sticky: a completed byte was dropped |
| err_underrun | output | 1 | Sticky: read attempted with nothing held |
| err_break | output | 1 | Sticky: all-zero frame with low stop bit |

## Verification
The critical coincidence is a frame completing in the same cycle as the consumer's read of the previous byte. The bench provokes it by holding one byte unread and then sweeping a one-cycle `rx_ready` pulse across every clock offset around the stop-bit sample of the next frame, with a reset before each trial. At every offset, the only acceptable results are "new byte held, no overrun" or "old byte read, overrun set". The first result must be seen up to some offset and the second from then on, and both must appear during the sweep.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int STOP_BITS  = 1,
  parameter int OVERSAMPLE = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en,
  input  logic                 rxd,
  output logic                 frame_done,
  output logic                 frame_stop_ok,
  output logic [DATA_BITS-1:0] frame_byte
);
  localparam int CNT_W  = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W  = $clog2(DATA_BITS + 1);
  localparam int STOP_W = $clog2(STOP_BITS + 1);
  localparam logic [CNT_W-1:0]  LAST_TICK = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0]  MID_TICK  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_BITS - 1);
  localparam logic [STOP_W-1:0] LAST_STOP = STOP_W'(STOP_BITS - 1);

  rx_state_t             state;
  logic [CNT_W-1:0]      tick_cnt;
  logic [BIT_W-1:0]      bit_cnt;
  logic [STOP_W-1:0]     stop_cnt;
  logic                  stop_bad;
  logic [DATA_BITS-1:0]  shreg;

  assign frame_byte = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= RX_IDLE;
      tick_cnt      <= '0;
      bit_cnt       <= '0;
      stop_cnt      <= '0;
      stop_bad      <= 1'b0;
      shreg         <= '0;
      frame_done    <= 1'b0;
      frame_stop_ok <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (sample_en) begin
        case (state)
          RX_IDLE: begin
            if (!rxd) begin
              state    <= RX_START;
              tick_cnt <= '0;
            end
          end
          RX_START: begin
            if (tick_cnt == MID_TICK) begin
              tick_cnt <= '0;
              if (!rxd) begin
                state   <= RX_DATA;
                bit_cnt <= '0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (tick_cnt == LAST_TICK) begin
              tick_cnt <= '0;
              shreg    <= {rxd, shreg[DATA_BITS-1:1]};
              if (bit_cnt == LAST_BIT) begin
                state    <= RX_STOP;
                stop_cnt <= '0;
                stop_bad <= 1'b0;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (tick_cnt == LAST_TICK) begin
              tick_cnt <= '0;
              if (stop_cnt == LAST_STOP) begin
                frame_done    <= 1'b1;
                frame_stop_ok <= rxd && !stop_bad;
                state         <= rxd ? RX_IDLE : RX_WAIT_HIGH;
              end else begin
                stop_cnt <= stop_cnt + 1'b1;
                stop_bad <= stop_bad | !rxd;
              end
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          RX_WAIT_HIGH: begin
            if (rxd) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_wait_no_frame_r10: assert property (@(posedge clk) disable iff (rst)
    (state == RX_WAIT_HIGH) |=> !frame_done);
endmodule

// File: rtl/serial_rx_holding.sv
module serial_rx_holding #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_done,
  input  logic                 frame_stop_ok,
  input  logic [DATA_BITS-1:0] frame_byte,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 err_overrun,
  output logic                 err_underrun,
  output logic                 err_break
);
  logic good_frame;
  logic consume;
  logic bad_zero;

  assign good_frame = frame_done && frame_stop_ok;
  assign consume    = rx_valid && rx_ready;
  assign bad_zero   = frame_done && !frame_stop_ok && (frame_byte == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      err_overrun  <= 1'b0;
      err_underrun <= 1'b0;
      err_break    <= 1'b0;
    end else begin
      if (good_frame && (!rx_valid || rx_ready)) begin
        rx_data  <= frame_byte;
        rx_valid <= 1'b1;
      end else if (consume) begin
        rx_valid <= 1'b0;
      end
      if (good_frame && rx_valid && !rx_ready) err_overrun  <= 1'b1;
      if (rx_ready && !rx_valid)               err_underrun <= 1'b1;
      if (bad_zero)                            err_break    <= 1'b1;
    end
  end

  p_hold_until_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_overrun_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_stop_ok && rx_valid && !rx_ready)
      |=> (err_overrun && $stable(rx_data)));

  p_coincide_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_stop_ok && rx_valid && rx_ready)
      |=> (rx_valid && rx_data == $past(frame_byte) && !$rose(err_overrun)));

  p_underrun_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !rx_valid) |=> err_underrun);

  p_break_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_stop_ok) |=> !$rose(rx_valid));

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err_overrun || err_underrun || err_break)
      |=> ($countones({err_overrun, err_underrun, err_break}) >=
           $countones($past({err_overrun, err_underrun, err_break}))));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DATA_BITS   = 8,
  parameter int STOP_BITS   = 1,
  parameter int OVERSAMPLE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en,
  input  logic                 rxd,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 err_overrun,
  output logic                 err_underrun,
  output logic                 err_break
);
  logic                 rxd_sync;
  logic                 frame_done;
  logic                 frame_stop_ok;
  logic [DATA_BITS-1:0] frame_byte;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (rxd_sync)
  );

  serial_rx_framer #(
    .DATA_BITS  (DATA_BITS),
    .STOP_BITS  (STOP_BITS),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_framer (
    .clk           (clk),
    .rst           (rst),
    .sample_en     (sample_en),
    .rxd           (rxd_sync),
    .frame_done    (frame_done),
    .frame_stop_ok (frame_stop_ok),
    .frame_byte    (frame_byte)
  );

  serial_rx_holding #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk           (clk),
    .rst           (rst),
    .frame_done    (frame_done),
    .frame_stop_ok (frame_stop_ok),
    .frame_byte    (frame_byte),
    .rx_ready      (rx_ready),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .err_overrun   (err_overrun),
    .err_underrun  (err_underrun),
    .err_break     (err_break)
  );
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb_top;
  localparam int OS       = 8;
  localparam int DIV      = 4;
  localparam int BIT_CLKS = OS * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, err_overrun, err_underrun, err_break;

  int checks = 0;
  int errors = 0;
  int div_cnt = 0;
  bit finished = 0;

  bit       m_valid, m_ovr, m_und, m_brk;
  bit [7:0] m_data;

  serial_rx_core #(.OVERSAMPLE(OS)) dut_i (
    .clk(clk), .rst(rst), .sample_en(sample_en), .rxd(rxd),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_overrun(err_overrun), .err_underrun(err_underrun), .err_break(err_break)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    sample_en = (div_cnt == 0);
    div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
  end

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    check(req, {rx_valid, err_overrun, err_underrun, err_break, rx_data},
               {m_valid, m_ovr, m_und, m_brk, m_data});
  endtask

  task automatic do_reset();
    rst = 1'b1; rxd = 1'b1; rx_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    m_valid = 0; m_ovr = 0; m_und = 0; m_brk = 0; m_data = 8'h00;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v);
    rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd = stop_v;
    repeat (BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic void model_frame(input logic [7:0] b, input logic stop_ok);
    if (stop_ok) begin
      if (m_valid) m_ovr = 1;
      else begin m_valid = 1; m_data = b; end
    end else if (b == 8'h00) m_brk = 1;
  endfunction

  task automatic do_read();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    if (m_valid) m_valid = 0; else m_und = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen_a, seen_c, order_bad;
    void'($urandom(32'd2024));
    do_reset();
    check_model("R1 reset state");

    send_frame(8'hA5, 1'b1); model_frame(8'hA5, 1);
    check_model("R2 byte A5");
    do_read(); check_model("R4 consume clears valid, data kept");
    send_frame(8'h3C, 1'b1); model_frame(8'h3C, 1);
    check_model("R2 byte 3C");

    // R5 hold during next frame, then R6 overrun
    fork
      send_frame(8'hC3, 1'b1);
      begin repeat (150) @(negedge clk); check("R5 data held mid-frame", {4'h0, rx_data}, 12'h03C); end
    join
    model_frame(8'hC3, 1);
    check_model("R6 overrun keeps old byte");
    do_read(); check_model("R4 read after overrun");
    do_read(); check_model("R8 underrun on empty read");
    send_frame(8'h66, 1'b1); model_frame(8'h66, 1);
    do_read(); check_model("R11 flags stay set");

    // R3 short low glitch
    do_reset();
    rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check_model("R3 glitch ignored");
    send_frame(8'h81, 1'b1); model_frame(8'h81, 1);
    check_model("R3 frame after glitch");
    do_read();

    // R9 framing error with nonzero data, then break
    send_frame(8'h7E, 1'b0); model_frame(8'h7E, 0);
    check_model("R9 bad stop nonzero dropped, no break");
    rxd = 1'b0; repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) repeat (BIT_CLKS) @(negedge clk);
    repeat (6 * BIT_CLKS) @(negedge clk);
    model_frame(8'h00, 0);
    check_model("R10 stuck low line gives no byte, R9 break set");
    rxd = 1'b1; repeat (2 * BIT_CLKS) @(negedge clk);
    check_model("R10 no byte after release");
    send_frame(8'h42, 1'b1); model_frame(8'h42, 1);
    check_model("R10 recovery after break");

    // random traffic
    do_reset();
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      logic sok;
      b = 8'($urandom);
      if (($urandom % 10) == 0) b = 8'h00;
      sok = (($urandom % 6) != 0);
      send_frame(b, sok); model_frame(b, sok);
      check_model("R2 R6 R9 random frame");
      if (($urandom % 3) != 0) begin
        do_read(); check_model("R4 R8 random read");
      end
    end

    // R7 coincidence sweep
    seen_a = 0; seen_c = 0; order_bad = 0;
    for (int k = 280; k <= 330; k++) begin
      do_reset();
      send_frame(8'h11, 1'b1);
      fork
        send_frame(8'h99, 1'b1);
        begin repeat (k) @(negedge clk); rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; end
      join
      repeat (4) @(negedge clk);
      if ({rx_valid, err_overrun, err_underrun, err_break, rx_data} == 12'h899) begin
        seen_a = 1; if (seen_c) order_bad = 1;
        checks++;
      end else if ({rx_valid, err_overrun, err_underrun, err_break, rx_data} == 12'h411) begin
        seen_c = 1; checks++;
      end else begin
        check("R7 sweep outcome", {rx_valid, err_overrun, err_underrun, err_break, rx_data}, 12'h899);
      end
    end
    check("R7 both outcomes seen", {10'h0, seen_a, seen_c}, 12'h003);
    check("R7 monotonic outcome order", {11'h0, order_bad}, 12'h000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule